// File: doc/BRIEF.md
# SMBus Register Slave for Clock Control Bytes

This block is a two-wire SMBus-compatible slave that holds a small bank of eight 8-bit control bytes. Some of its register bits are consumed elsewhere in the chip. A host can reach the bank in two ways: one indexed byte at a time, or as a block that always begins at index 0 and climbs upward. The command byte that follows the address selects between the two. Data moves most significant bit first, and the host may end any transfer with a stop after any whole byte.

The serial lines are brought into the system clock domain through synchronizers and glitch filters. Bus events are detected on the filtered levels: start, repeated start, stop and the clock edges. Index 0 reflects a pair of strap inputs, and index 7 is a fixed identification byte. Both are read-only. Indices 1 to 6 are writable, reset to fixed defaults, and are presented as a flat bus on `cfg_o`.

Top module: `smbus_regslave`

## Requirements
- R1: SCL and SDA are synchronized and filtered. A pulse shorter than FILT system clocks on either line causes no bit, no start and no stop.
- R2: The slave acknowledges only the 7-bit address 0x69 (byte 0xD2 for a write, 0xD3 for a read). Any other address is left unacknowledged, and the rest of that transfer is ignored.
- R3: A command byte with bit 7 set begins a byte access, with bits 6:0 giving the index. A following data byte is acknowledged and stored at that index.
- R4: After a byte-access command, a repeated start and the read address, the slave returns the indexed byte MSB first.
- R5: A command byte of 0x00 begins a block access. In a write, the host sends a count byte and then data bytes, which are stored at index 0, 1, 2 and onward. A stop after any byte leaves the later indices unchanged.
- R6: A block read returns the count value 8 first and then the bytes of index 0 upward, for as long as the host acknowledges. A host NACK ends the transfer.
- R7: Reset loads indices 1..6 with 7F, 00, FF, 07, DF, 03. `cfg_o[8*k-1 -: 8]` shows index k.
- R8: Index 0 reads {6'b0, strap_i}, and index 7 reads 0x08. Writes to index 0, to index 7, or to any index of 8 or above are acknowledged and have no effect. Reads of index 8 or above return 0x00.
- R9: `sda_oe_o` is low whenever the slave is idle, and it only becomes asserted while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Strap levels reflected in index 0 |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| cfg_o | output | 48 | Indices 1..6, index 1 in the low byte |

## Verification
An index pointer that has drifted appears at the ports at once: the next data byte read back over the bus, or the byte that changes on `cfg_o` after a write, is the neighbour of the one expected. A mistracked bit count or phase shows up within the same byte as a missing acknowledge, a byte shifted by one position, or SDA still held low when the host tries to stop. Because reads, `cfg_o` and the acknowledge returned for each byte are all compared against a model after every transfer, a wrong register value is exposed no later than the next access to that index.

// File: rtl/smbus_pkg.sv
package smbus_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_CMD,
    RL_COUNT,
    RL_DATA
  } role_e;
endpackage

// File: rtl/smbus_glitch_filter.sv
module smbus_glitch_filter #(
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT + 1);

  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      line_o <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], line_i};
      if (sync_q[SYNC-1] != line_o) begin
        if (cnt_q == CW'(FILT - 1)) begin
          line_o <= sync_q[SYNC-1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R1: a filtered change always adopts the synchronized level
  a_r1_filter_follows: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_o) |-> line_o == $past(sync_q[SYNC-1]));
endmodule

// File: rtl/smbus_regbank.sv
module smbus_regbank
  import smbus_pkg::*;
#(
  parameter int              NREG      = 8,
  parameter int              STRAP_W   = 2,
  parameter logic [BYTE_W-1:0] VENDOR_ID = 8'h08
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [OFS_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  input  logic [OFS_W-1:0]             rd_addr,
  output logic [BYTE_W-1:0]            rd_data,
  input  logic [STRAP_W-1:0]           strap_i,
  output logic [(NREG-2)*BYTE_W-1:0]   cfg_o
);
  localparam int IW = $clog2(NREG);
  localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(NREG - 1);

  logic [BYTE_W-1:0] mem_q [NREG];
  logic              wr_ok;

  function automatic logic [BYTE_W-1:0] dflt(input int idx);
    case (idx)
      1:       return 8'h7F;
      2:       return 8'h00;
      3:       return 8'hFF;
      4:       return 8'h07;
      5:       return 8'hDF;
      6:       return 8'h03;
      default: return '0;
    endcase
  endfunction

  assign wr_ok = wr_en && (wr_addr != '0) && (wr_addr < LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= dflt(i);
    end else if (wr_ok) begin
      mem_q[wr_addr[IW-1:0]] <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr == '0)            rd_data = BYTE_W'(strap_i);
    else if (rd_addr == LAST_IDX) rd_data = VENDOR_ID;
    else if (rd_addr < LAST_IDX)  rd_data = mem_q[rd_addr[IW-1:0]];
    else                          rd_data = '0;
  end

  for (genvar g = 1; g <= NREG - 2; g++) begin : g_cfg
    assign cfg_o[(g-1)*BYTE_W +: BYTE_W] = mem_q[g];
  end

  // R3: without a write strobe the visible configuration never moves
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_o));

  // R8: strobes aimed at read-only or absent indices leave the bank unchanged
  a_r8_ro_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == '0 || wr_addr >= LAST_IDX)) |=> $stable(cfg_o));
endmodule

// File: rtl/smbus_regslave.sv
module smbus_regslave
  import smbus_pkg::*;
#(
  parameter logic [6:0]        ADDR7     = 7'h69,
  parameter int                NREG      = 8,
  parameter int                STRAP_W   = 2,
  parameter int                SYNC      = 2,
  parameter int                FILT      = 3,
  parameter int                BLK_COUNT = 8,
  parameter logic [BYTE_W-1:0] VENDOR_ID = 8'h08
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [STRAP_W-1:0]         strap_i,
  output logic                       sda_oe_o,
  output logic [(NREG-2)*BYTE_W-1:0] cfg_o
);
  localparam int CW = $clog2(BYTE_W + 1);

  logic scl_f, sda_f, scl_d, sda_d;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  phase_e            phase_q;
  role_e             role_q;
  logic              rw_q, blk_q, cnt_first_q, m_ack_q;
  logic [OFS_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] rx_sh, tx_sh, rd_data, tx_next;
  logic [CW-1:0]     bit_cnt;
  logic              byte_done, wr_en;

  smbus_glitch_filter #(.SYNC(SYNC), .FILT(FILT)) u_scl_filt (
    .clk(clk), .rst(rst), .line_i(scl_i), .line_o(scl_f));
  smbus_glitch_filter #(.SYNC(SYNC), .FILT(FILT)) u_sda_filt (
    .clk(clk), .rst(rst), .line_i(sda_i), .line_o(sda_f));

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

  assign byte_done = (phase_q == PH_RX) && scl_fall && (bit_cnt == CW'(BYTE_W));
  assign wr_en     = byte_done && (role_q == RL_DATA);
  assign tx_next   = cnt_first_q ? BYTE_W'(BLK_COUNT) : rd_data;

  smbus_regbank #(.NREG(NREG), .STRAP_W(STRAP_W), .VENDOR_ID(VENDOR_ID)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(ptr_q), .wr_data(rx_sh),
    .rd_addr(ptr_q), .rd_data(rd_data), .strap_i(strap_i), .cfg_o(cfg_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      role_q      <= RL_ADDR;
      rw_q        <= 1'b0;
      blk_q       <= 1'b0;
      cnt_first_q <= 1'b0;
      m_ack_q     <= 1'b0;
      ptr_q       <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      bit_cnt     <= '0;
      sda_oe_o    <= 1'b0;
    end else if (start_ev) begin
      phase_q  <= PH_RX;
      role_q   <= RL_ADDR;
      rw_q     <= 1'b0;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_ev) begin
      phase_q  <= PH_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (phase_q)
        PH_RX: begin
          if (scl_rise && bit_cnt < CW'(BYTE_W)) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            phase_q  <= PH_RX_ACK;
            sda_oe_o <= 1'b1;
            case (role_q)
              RL_ADDR: begin
                if (rx_sh[BYTE_W-1:1] == ADDR7) begin
                  rw_q        <= rx_sh[0];
                  cnt_first_q <= blk_q;
                  role_q      <= RL_CMD;
                end else begin
                  phase_q  <= PH_IDLE;
                  sda_oe_o <= 1'b0;
                end
              end
              RL_CMD: begin
                blk_q  <= ~rx_sh[BYTE_W-1];
                ptr_q  <= rx_sh[BYTE_W-1] ? rx_sh[OFS_W-1:0] : '0;
                role_q <= rx_sh[BYTE_W-1] ? RL_DATA : RL_COUNT;
              end
              RL_COUNT: role_q <= RL_DATA;
              default:  ptr_q  <= ptr_q + 1'b1;
            endcase
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              phase_q  <= PH_TX;
              tx_sh    <= tx_next;
              sda_oe_o <= ~tx_next[BYTE_W-1];
              if (cnt_first_q) cnt_first_q <= 1'b0;
              else             ptr_q       <= ptr_q + 1'b1;
            end else begin
              phase_q  <= PH_RX;
              sda_oe_o <= 1'b0;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bit_cnt == CW'(BYTE_W - 1)) begin
              phase_q  <= PH_TX_ACK;
              sda_oe_o <= 1'b0;
            end else begin
              tx_sh    <= tx_sh << 1;
              sda_oe_o <= ~tx_sh[BYTE_W-2];
              bit_cnt  <= bit_cnt + 1'b1;
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) m_ack_q <= ~sda_f;
          if (scl_fall) begin
            if (m_ack_q) begin
              phase_q  <= PH_TX;
              bit_cnt  <= '0;
              tx_sh    <= tx_next;
              sda_oe_o <= ~tx_next[BYTE_W-1];
              if (cnt_first_q) cnt_first_q <= 1'b0;
              else             ptr_q       <= ptr_q + 1'b1;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9: an idle slave never holds the data line
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> !sda_oe_o);

  // R9: the slave starts pulling SDA only while the clock line is low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_f);

  // R2: the receive bit counter never passes one byte
  a_r2_bitcnt_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(BYTE_W));
endmodule

// File: tb/smbus_regslave_tb.sv
module smbus_regslave_tb;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m_low = 1'b0;
  logic [1:0]  strap = 2'b01;
  logic        sda_oe;
  logic [47:0] cfg;
  wire         sda_line = ~(sda_oe | sda_m_low);

  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];

  always #2 clk = ~clk;

  smbus_regslave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .cfg_o(cfg));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int idx);
    if (idx == 0) return {6'b0, strap};
    if (idx == 7) return 8'h08;
    if (idx < 8)  return model[idx];
    return 8'h00;
  endfunction

  function automatic logic [47:0] exp_cfg();
    return {model[6], model[5], model[4], model[3], model[2], model[1]};
  endfunction

  task automatic bus_start();
    sda_m_low = 1'b0; tick(Q);
    scl_m = 1'b1;     tick(Q);
    sda_m_low = 1'b1; tick(Q);
    scl_m = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1; tick(Q);
    scl_m = 1'b1;     tick(Q);
    sda_m_low = 1'b0; tick(Q);
  endtask

  task automatic bit_out(input logic b, input logic glitch);
    sda_m_low = ~b; tick(Q/2);
    if (glitch) begin scl_m = 1'b1; tick(1); scl_m = 1'b0; end
    tick(Q/2);
    scl_m = 1'b1; tick(Q/2);
    if (glitch && b) begin sda_m_low = 1'b1; tick(1); sda_m_low = 1'b0; end
    tick(Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m_low = 1'b0; tick(Q);
    scl_m = 1'b1;     tick(Q);
    b = sda_line;
    scl_m = 1'b0;     tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, input logic glitch, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i], glitch && (i == 0 || i == 3));
    bit_in(a);
    acked = ~a;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~give_ack, 1'b0);
  endtask

  task automatic byte_write(input int off, input logic [7:0] d, input logic glitch, input string req);
    logic a;
    bus_start();
    wbyte(8'hD2, 1'b0, a);              check({req, " addr ack"}, a, 1'b1);
    wbyte(8'h80 | 8'(off), glitch, a);  check({req, " cmd ack"}, a, 1'b1);
    wbyte(d, 1'b0, a);                  check({req, " data ack"}, a, 1'b1);
    bus_stop();
    if (off >= 1 && off <= 6) model[off] = d;
    check({req, " cfg"}, cfg, exp_cfg());
  endtask

  task automatic byte_read(input int off, input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD2, 1'b0, a);
    wbyte(8'h80 | 8'(off), 1'b0, a);
    bus_start();
    wbyte(8'hD3, 1'b0, a);              check({req, " rd addr ack"}, a, 1'b1);
    rbyte(1'b0, d);
    bus_stop();
    check({req, " read data"}, d, exp_reg(off));
  endtask

  task automatic block_write(input int n, input logic [7:0] seed);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD2, 1'b0, a);
    wbyte(8'h00, 1'b0, a);
    wbyte(8'(n), 1'b0, a);              check("R5 count ack", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      d = seed ^ 8'(i * 37);
      wbyte(d, 1'b0, a);
      if (i >= 1 && i <= 6) model[i] = d;
    end
    check("R5 last data ack", a, 1'b1);
    bus_stop();
    check("R5 cfg after block write", cfg, exp_cfg());
  endtask

  task automatic block_read(input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD2, 1'b0, a);
    wbyte(8'h00, 1'b0, a);
    bus_start();
    wbyte(8'hD3, 1'b0, a);
    rbyte(1'b1, d);                      check("R6 block count", d, 8'd8);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, d);
      check("R6 block data", d, exp_reg(i));
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic a;
    int op, off, n;
    logic [7:0] d;
    off = $urandom(32'h1234);
    model[0] = 8'h00; model[1] = 8'h7F; model[2] = 8'h00; model[3] = 8'hFF;
    model[4] = 8'h07; model[5] = 8'hDF; model[6] = 8'h03; model[7] = 8'h08;
    tick(5);
    rst = 1'b0;
    tick(5);
    // R7 reset defaults, R9 released at reset
    check("R7 reset cfg", cfg, 48'h03DF07FF007F);
    check("R9 sda released at reset", sda_oe, 1'b0);
    // R4 R7 R8 read every index
    for (int i = 0; i < 8; i++) byte_read(i, "R4 R7");
    byte_read(9, "R8 out of range");
    // R2 wrong address
    bus_start();
    wbyte(8'hD4, 1'b0, a);
    check("R2 foreign address nack", a, 1'b0);
    wbyte(8'h81, 1'b0, a);
    wbyte(8'h55, 1'b0, a);
    bus_stop();
    check("R2 foreign write ignored", cfg, exp_cfg());
    check("R9 idle after nack", sda_oe, 1'b0);
    // R3 writes, R8 read-only targets
    byte_write(2, 8'hA5, 1'b0, "R3");
    byte_read(2, "R3");
    byte_write(0, 8'hFF, 1'b0, "R8 idx0");
    byte_write(7, 8'h77, 1'b0, "R8 idx7");
    byte_write(12, 8'h11, 1'b0, "R8 idx12");
    byte_read(0, "R8 idx0");
    byte_read(7, "R8 idx7");
    strap = 2'b10;
    byte_read(0, "R8 strap");
    // R1 glitches on SCL and SDA inside the command byte
    byte_write(5, 8'h3C, 1'b1, "R1 glitch");
    byte_read(5, "R1 glitch");
    // R5 full and partial block writes, R6 block reads
    block_write(8, 8'h5A);
    block_read(8);
    block_write(3, 8'hC3);
    block_read(5);
    // random mix
    for (int k = 0; k < 30; k++) begin
      op  = $urandom_range(0, 3);
      off = $urandom_range(0, 9);
      d   = 8'($urandom);
      n   = $urandom_range(1, 8);
      case (op)
        0: byte_write(off, d, 1'b0, "R3 random");
        1: byte_read(off, "R4 random");
        2: block_write(n, d);
        default: block_read(n);
      endcase
      check("R9 released after transfer", sda_oe, 1'b0);
    end
    finish_run();
  end
endmodule